// File: doc/BRIEF.md
# ADC Conversion Request Sequencer

This block sits in front of one analog-to-digital converter core and decides which conversion runs next. It holds sixteen conversion slots. Each slot is set up with three things: the trigger line that requests it, the analog input channel it converts, and the length of its sample window. A pulse on a trigger line marks every slot listening to that line as pending. An arbiter then picks one pending slot at a time and runs its conversion. It drives the channel select, holds the sample window open, and then pulses start-of-conversion toward the converter.

After a fixed conversion time, the converter output is stored in the result register that belongs to the slot. Results are read back through a registered read port. Nine interrupt lines can each be tied to a slot. Each line pulses either when that slot's result lands or early, when its conversion starts.

Arbitration is set by a boundary value. Slots below the boundary are high priority, and among them the lowest index wins. All other slots share a round-robin group. The round-robin search starts just after the round-robin slot that was converted last.

Top module: `adc_seq_top`

## Requirements
- R1: A one-cycle pulse on trigger line k (`trig_in[k]`) makes every slot whose source field equals k pending. Each such slot is then converted exactly once.
- R2: From the first window cycle until the result is stored, `adc_chan` carries the channel field of the slot being serviced.
- R3: For window field W, `adc_sample` is high for exactly W+1 consecutive cycles. `adc_soc` is high for exactly the one cycle right after the window closes.
- R4: The conversion takes 13 cycles after `adc_soc`. At its end, `adc_data` is stored in the result register indexed by the slot number. Setting `rd_addr` = s returns that register on `rd_data` one cycle later.
- R5: Round-robin order: with `prio_bound` = 0, the first pending slot at or after (last round-robin slot converted + 1), wrapping modulo 16, is serviced next. After reset the search starts at slot 0.
- R6: Priority order: any pending slot with index below `prio_bound` is serviced before every round-robin slot, lowest index first. Servicing these slots does not move the round-robin starting point.
- R7: A trigger for a slot that is still pending sets that slot's bit in `ovf_out` and is not queued a second time. The bit stays set until the slot's configuration is written again.
- R8: A slot's pending state clears when its sample window begins. A trigger arriving during the slot's own window or conversion is taken as a new request, without overflow.
- R9: An interrupt line that is enabled, set to end mode and tied to slot s pulses `irq_out` for one cycle. The pulse comes 13 cycles after the `adc_soc` of slot s, in the cycle its result becomes readable.
- R10: An interrupt line that is enabled, set to early mode and tied to slot s pulses in the same cycle as the `adc_soc` of slot s.
- R11: A disabled interrupt line never pulses, and a line never pulses for a slot other than its own.
- R12: While reset is asserted and right after it, `adc_sample`, `adc_soc`, `irq_out` and `ovf_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write slot configuration; also clears that slot's overflow bit |
| cfg_slot | input | 4 | Slot being configured |
| cfg_src | input | 3 | Trigger line index for the slot |
| cfg_chan | input | 4 | Analog channel for the slot |
| cfg_win | input | 6 | Window field W (window is W+1 cycles) |
| irq_cfg_we | input | 1 | Write interrupt line configuration |
| irq_cfg_line | input | 4 | Interrupt line being configured (0..8) |
| irq_cfg_slot | input | 4 | Slot tied to the line |
| irq_cfg_en | input | 1 | Line enable |
| irq_cfg_early | input | 1 | 1 = pulse at start of conversion, 0 = at result |
| prio_bound | input | 5 | Slots with index below this value are high priority |
| trig_in | input | 8 | Trigger pulses, one per source line |
| adc_chan | output | 4 | Channel mux select |
| adc_sample | output | 1 | Sample window active |
| adc_soc | output | 1 | Start-of-conversion pulse |
| adc_data | input | 12 | Converter result, taken at end of conversion |
| rd_addr | input | 4 | Result register to read |
| rd_data | output | 12 | Registered result read data |
| irq_out | output | 9 | Interrupt pulses |
| ovf_out | output | 16 | Sticky per-slot overflow bits |

## Verification
Each slot has a distinct channel, and the converter stub returns a value computed from the channel. The bench can therefore tell which slot was serviced, and into which register its result went, just by watching the outputs. A sweep over the trigger lines fires slots in pairs that share a line. This separates correct source decoding from the round-robin pointer moving between pairs. A trigger on all lines at once with no boundary exposes the full round-robin order. The same burst with a boundary of four, plus a mid-burst retrigger of a priority slot and of an already-pending slot, separates priority from round-robin and overflow from a genuine new request. A self-retrigger during a slot's own window distinguishes "pending cleared at window start" from "cleared at end". Early, end and disabled interrupt lines tied to one slot are timed against its start-of-conversion pulse.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SAMP = 2'd1,
    ST_CONV = 2'd2
  } seq_st_e;
endpackage

// File: rtl/adc_seq_pend.sv
// Per-slot request latch with overflow detection.
module adc_seq_pend #(
  parameter int NSLOT = 16,
  parameter int NSRC  = 8,
  parameter int SRW   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  trig_in,
  input  logic [SRW-1:0]   src_sel [NSLOT],
  input  logic [NSLOT-1:0] take_vec,
  input  logic [NSLOT-1:0] ovf_clr,
  output logic [NSLOT-1:0] pend,
  output logic [NSLOT-1:0] ovf
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic hit;
    assign hit = trig_in[src_sel[g]];
    always_ff @(posedge clk) begin
      if (rst) begin
        pend[g] <= 1'b0;
        ovf[g]  <= 1'b0;
      end else begin
        // a new trigger wins over the clear issued at window start
        pend[g] <= (pend[g] & ~take_vec[g]) | hit;
        if (ovf_clr[g]) ovf[g] <= 1'b0;
        else if (hit && pend[g] && !take_vec[g]) ovf[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_seq_arb.sv
// Combinational pick: priority group first, then round-robin group.
module adc_seq_arb #(
  parameter int NSLOT = 16,
  parameter int SLW   = 4
) (
  input  logic [NSLOT-1:0] pend,
  input  logic [SLW:0]     bound,
  input  logic [SLW-1:0]   rr_last,
  output logic             found,
  output logic [SLW-1:0]   idx,
  output logic             is_hi
);
  logic           hi_f, rr_f;
  logic [SLW-1:0] hi_i, rr_i;

  always_comb begin
    hi_f = 1'b0;
    hi_i = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (pend[i] && (i < int'(bound))) begin
        hi_f = 1'b1;
        hi_i = SLW'(i);
      end
    end
    rr_f = 1'b0;
    rr_i = '0;
    for (int k = NSLOT; k >= 1; k--) begin
      int j;
      j = int'(rr_last) + k;
      if (j >= NSLOT) j = j - NSLOT;
      if (pend[j] && (j >= int'(bound))) begin
        rr_f = 1'b1;
        rr_i = SLW'(j);
      end
    end
    found = hi_f | rr_f;
    is_hi = hi_f;
    idx   = hi_f ? hi_i : rr_i;
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
// Window / conversion timing of the serviced slot.
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SLW       = 4,
  parameter int CHW       = 4,
  parameter int WW        = 6,
  parameter int CONV_CLKS = 13,
  parameter int CNTW      = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           found,
  input  logic [SLW-1:0] pick_idx,
  input  logic           pick_hi,
  input  logic [CHW-1:0] pick_chan,
  input  logic [WW-1:0]  pick_win,
  output logic           take,
  output logic           soc_now,
  output logic           eoc_now,
  output logic           sample,
  output logic           soc,
  output logic [CHW-1:0] chan,
  output logic [SLW-1:0] cur_slot,
  output logic           cur_hi
);
  seq_st_e         st;
  logic [CNTW-1:0] cnt;

  assign take    = found && (st == ST_IDLE);
  assign soc_now = (st == ST_SAMP) && (cnt == '0);
  assign eoc_now = (st == ST_CONV) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      sample   <= 1'b0;
      soc      <= 1'b0;
      chan     <= '0;
      cur_slot <= '0;
      cur_hi   <= 1'b0;
    end else begin
      soc <= soc_now;
      case (st)
        ST_IDLE: if (take) begin
          st       <= ST_SAMP;
          cnt      <= CNTW'(pick_win);
          sample   <= 1'b1;
          chan     <= pick_chan;
          cur_slot <= pick_idx;
          cur_hi   <= pick_hi;
        end
        ST_SAMP: if (cnt == '0) begin
          st     <= ST_CONV;
          cnt    <= CNTW'(CONV_CLKS - 1);
          sample <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
        ST_CONV: if (cnt == '0) st <= ST_IDLE;
                 else cnt <= cnt - 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
  parameter int NSLOT     = 16,
  parameter int NSRC      = 8,
  parameter int NCH       = 16,
  parameter int WW        = 6,
  parameter int CONV_CLKS = 13,
  parameter int DW        = 12,
  parameter int NIRQ      = 9
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [$clog2(NSLOT)-1:0] cfg_slot,
  input  logic [$clog2(NSRC)-1:0]  cfg_src,
  input  logic [$clog2(NCH)-1:0]   cfg_chan,
  input  logic [WW-1:0]            cfg_win,
  input  logic                     irq_cfg_we,
  input  logic [$clog2(NIRQ)-1:0]  irq_cfg_line,
  input  logic [$clog2(NSLOT)-1:0] irq_cfg_slot,
  input  logic                     irq_cfg_en,
  input  logic                     irq_cfg_early,
  input  logic [$clog2(NSLOT):0]   prio_bound,
  input  logic [NSRC-1:0]          trig_in,
  output logic [$clog2(NCH)-1:0]   adc_chan,
  output logic                     adc_sample,
  output logic                     adc_soc,
  input  logic [DW-1:0]            adc_data,
  input  logic [$clog2(NSLOT)-1:0] rd_addr,
  output logic [DW-1:0]            rd_data,
  output logic [NIRQ-1:0]          irq_out,
  output logic [NSLOT-1:0]         ovf_out
);
  localparam int SLW  = $clog2(NSLOT);
  localparam int SRW  = $clog2(NSRC);
  localparam int CHW  = $clog2(NCH);
  localparam int CCW  = $clog2(CONV_CLKS);
  localparam int CNTW = (WW > CCW) ? WW : CCW;

  logic [SRW-1:0] src_q  [NSLOT];
  logic [CHW-1:0] chan_q [NSLOT];
  logic [WW-1:0]  win_q  [NSLOT];
  logic           ie_q   [NIRQ];
  logic           iery_q [NIRQ];
  logic [SLW-1:0] isl_q  [NIRQ];
  logic [DW-1:0]  res_mem [NSLOT];

  logic [NSLOT-1:0] pend, take_vec, ovf_clr;
  logic             found, is_hi, take, soc_now, eoc_now, cur_hi;
  logic [SLW-1:0]   win_idx, cur_slot, rr_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NSLOT; s++) begin
        src_q[s]  <= '0;
        chan_q[s] <= '0;
        win_q[s]  <= '0;
      end
      for (int q = 0; q < NIRQ; q++) begin
        ie_q[q]   <= 1'b0;
        iery_q[q] <= 1'b0;
        isl_q[q]  <= '0;
      end
    end else begin
      if (cfg_we) begin
        src_q[cfg_slot]  <= cfg_src;
        chan_q[cfg_slot] <= cfg_chan;
        win_q[cfg_slot]  <= cfg_win;
      end
      if (irq_cfg_we && (int'(irq_cfg_line) < NIRQ)) begin
        ie_q[irq_cfg_line]   <= irq_cfg_en;
        iery_q[irq_cfg_line] <= irq_cfg_early;
        isl_q[irq_cfg_line]  <= irq_cfg_slot;
      end
    end
  end

  assign take_vec = take ? (NSLOT'(1) << win_idx) : '0;
  assign ovf_clr  = cfg_we ? (NSLOT'(1) << cfg_slot) : '0;

  adc_seq_pend #(.NSLOT(NSLOT), .NSRC(NSRC), .SRW(SRW)) u_pend (
    .clk(clk), .rst(rst), .trig_in(trig_in), .src_sel(src_q),
    .take_vec(take_vec), .ovf_clr(ovf_clr), .pend(pend), .ovf(ovf_out)
  );

  adc_seq_arb #(.NSLOT(NSLOT), .SLW(SLW)) u_arb (
    .pend(pend), .bound(prio_bound), .rr_last(rr_last),
    .found(found), .idx(win_idx), .is_hi(is_hi)
  );

  adc_seq_ctrl #(.SLW(SLW), .CHW(CHW), .WW(WW), .CONV_CLKS(CONV_CLKS), .CNTW(CNTW)) u_ctrl (
    .clk(clk), .rst(rst), .found(found), .pick_idx(win_idx), .pick_hi(is_hi),
    .pick_chan(chan_q[win_idx]), .pick_win(win_q[win_idx]),
    .take(take), .soc_now(soc_now), .eoc_now(eoc_now),
    .sample(adc_sample), .soc(adc_soc), .chan(adc_chan),
    .cur_slot(cur_slot), .cur_hi(cur_hi)
  );

  // round-robin pointer follows only the round-robin group
  always_ff @(posedge clk) begin
    if (rst) rr_last <= SLW'(NSLOT - 1);
    else if (eoc_now && !cur_hi) rr_last <= cur_slot;
  end

  // result store: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (eoc_now) res_mem[cur_slot] <= adc_data;
  end
  always_ff @(posedge clk) begin
    rd_data <= res_mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out <= '0;
    else begin
      for (int q = 0; q < NIRQ; q++)
        irq_out[q] <= ie_q[q] && (isl_q[q] == cur_slot) &&
                      (iery_q[q] ? soc_now : eoc_now);
    end
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int NSLOT     = 16,
  parameter int CHW       = 4,
  parameter int CONV_CLKS = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             adc_sample,
  input logic             adc_soc,
  input logic [CHW-1:0]   adc_chan,
  input logic             cfg_we,
  input logic [NSLOT-1:0] ovf_out
);
  localparam int GW = $clog2(CONV_CLKS + 1);
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst) gap <= '0;
    else if (adc_soc) gap <= GW'(CONV_CLKS);
    else if (gap != '0) gap <= gap - 1'b1;
  end

  // R3: start pulse follows the closing window
  a_r3_soc_after_window: assert property (@(posedge clk) disable iff (rst)
    adc_soc |-> (!adc_sample && $past(adc_sample)));
  // R3: start pulse lasts one cycle
  a_r3_soc_single: assert property (@(posedge clk) disable iff (rst)
    adc_soc |=> !adc_soc);
  // R2: channel held through the window
  a_r2_chan_stable: assert property (@(posedge clk) disable iff (rst)
    (adc_sample && $past(adc_sample)) |-> $stable(adc_chan));
  // R4: no new window before the conversion time has run out
  a_r4_conv_gap: assert property (@(posedge clk) disable iff (rst)
    !(adc_sample && (gap != '0)));
  // R7: overflow bits only fall after a configuration write
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_we) |-> ((ovf_out & $past(ovf_out)) == $past(ovf_out)));
endmodule

bind adc_seq_top adc_seq_chk #(.NSLOT(NSLOT), .CHW($clog2(NCH)), .CONV_CLKS(CONV_CLKS)) u_chk (
  .clk(clk), .rst(rst), .adc_sample(adc_sample), .adc_soc(adc_soc),
  .adc_chan(adc_chan), .cfg_we(cfg_we), .ovf_out(ovf_out)
);

// File: tb/tb_adc_seq_top.sv
`timescale 1ns/1ps
module tb_adc_seq_top;
  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0, irq_cfg_we = 0, irq_cfg_en = 0, irq_cfg_early = 0;
  logic [3:0] cfg_slot = 0, cfg_chan = 0, irq_cfg_line = 0, irq_cfg_slot = 0, rd_addr = 0;
  logic [2:0] cfg_src = 0;
  logic [5:0] cfg_win = 0;
  logic [4:0] prio_bound = 0;
  logic [7:0] trig_in = 0;
  logic [3:0] adc_chan;
  logic adc_sample, adc_soc;
  logic [11:0] adc_data, rd_data;
  logic [8:0] irq_out;
  logic [15:0] ovf_out;

  always #5 clk = ~clk;

  // converter stub: value depends on the selected channel only
  function automatic logic [11:0] conv_val(input int ch);
    return 12'((ch * 211 + 7) & 12'hFFF);
  endfunction
  assign adc_data = conv_val(int'(adc_chan));

  adc_seq_top dut (.*);

  function automatic int src_of(input int s); return s % 8; endfunction
  function automatic int chan_of(input int s); return (5 * s + 3) % 16; endfunction
  function automatic int win_of(input int s); return (s * 13 + 2) % 64; endfunction
  function automatic int slot_of_chan(input int c);
    for (int s = 0; s < 16; s++) if (chan_of(s) == c) return s;
    return -1;
  endfunction

  int n_tests = 0, n_fail = 0;
  int cyc = 0, n_start = 0, cur_len = 0, soc_bad = 0;
  int seq [512], lens [512], socc [512];
  int irq_cnt [9], irq_cyc [9];
  bit prev_s = 0;
  bit [15:0] m_ovf = 0;
  int m_last = 15;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial for (int i = 0; i < 9; i++) begin irq_cnt[i] = 0; irq_cyc[i] = 0; end

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (adc_sample && !prev_s) begin
        seq[n_start] = slot_of_chan(int'(adc_chan));
        cur_len = 1;
        n_start++;
      end else if (adc_sample) cur_len++;
      if (!adc_sample && prev_s) begin
        lens[n_start-1] = cur_len;
        if (!adc_soc) soc_bad++;
      end else if (adc_soc) soc_bad++;
      if (adc_soc && n_start > 0) socc[n_start-1] = cyc;
      for (int i = 0; i < 9; i++)
        if (irq_out[i]) begin irq_cnt[i]++; irq_cyc[i] = cyc; end
      prev_s = adc_sample;
    end
    if (cyc > 150000) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic cfg(input int s);
    @(negedge clk);
    cfg_we = 1; cfg_slot = 4'(s); cfg_src = 3'(src_of(s));
    cfg_chan = 4'(chan_of(s)); cfg_win = 6'(win_of(s));
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic cfg_irq(input int line, input int s, input bit en, input bit early);
    @(negedge clk);
    irq_cfg_we = 1; irq_cfg_line = 4'(line); irq_cfg_slot = 4'(s);
    irq_cfg_en = en; irq_cfg_early = early;
    @(negedge clk); irq_cfg_we = 0;
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk); trig_in = m;
    @(negedge clk); trig_in = 0;
  endtask

  function automatic int mpick(input bit [15:0] p, input int last, input int bound);
    for (int i = 0; i < 16; i++) if (p[i] && i < bound) return i;
    for (int k = 1; k <= 16; k++) begin
      int j;
      j = (last + k) % 16;
      if (p[j] && j >= bound) return j;
    end
    return -1;
  endfunction

  task automatic mapply(inout bit [15:0] p, input logic [7:0] m);
    for (int s = 0; s < 16; s++)
      if (m[src_of(s)]) begin
        if (p[s]) m_ovf[s] = 1'b1;
        p[s] = 1'b1;
      end
  endtask

  // run one burst and compare against the ordering model
  task automatic scenario(input logic [7:0] init, input int mid_at,
                          input logic [7:0] mid, input int bound, input string tag);
    bit [15:0] mp = 0;
    int expq [64];
    int ne = 0, base;
    base = n_start;
    mapply(mp, init);
    for (int k = 0; k < 64; k++) begin
      int w;
      if (k == mid_at) mapply(mp, mid);
      if (mp == 0) break;
      w = mpick(mp, m_last, bound);
      expq[ne] = w; ne++;
      mp[w] = 1'b0;
      if (w >= bound) m_last = w;
    end
    @(negedge clk); prio_bound = 5'(bound);
    pulse(init);
    if (mid_at >= 0) begin
      while (n_start < base + mid_at) @(negedge clk);
      pulse(mid);
    end
    while (n_start < base + ne) @(negedge clk);
    repeat (120) @(negedge clk);
    check(n_start == base + ne, {tag, " R1 conversion count"}, n_start - base, ne);
    for (int k = 0; k < ne; k++) begin
      check(seq[base+k] == expq[k], {tag, " R2 order/channel"}, seq[base+k], expq[k]);
      check(lens[base+k] == win_of(expq[k]) + 1, "R3 window length",
            lens[base+k], win_of(expq[k]) + 1);
    end
    check(ovf_out == m_ovf, {tag, " R7 overflow bits"}, int'(ovf_out), int'(m_ovf));
    for (int s = 0; s < 16; s++) if (m_ovf[s]) cfg(s);
    m_ovf = 0;
    @(negedge clk);
    check(ovf_out == 0, "R7 overflow cleared by config write", int'(ovf_out), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(adc_sample == 0 && adc_soc == 0, "R12 reset window/soc", int'(adc_sample), 0);
    check(irq_out == 0 && ovf_out == 0, "R12 reset irq/ovf", int'(irq_out), 0);
    rst = 0;
    @(negedge clk);
    check(adc_sample == 0 && irq_out == 0 && ovf_out == 0, "R12 after reset",
          int'(adc_sample), 0);
    for (int s = 0; s < 16; s++) cfg(s);

    // R1 sweep: each line fires its pair of slots
    for (int k = 0; k < 8; k++) scenario(8'(1 << k), -1, 8'h00, 0, "R1");
    for (int s = 0; s < 16; s++) begin
      @(negedge clk); rd_addr = 4'(s);
      @(negedge clk);
      check(rd_data == conv_val(chan_of(s)), "R4 result at slot index",
            int'(rd_data), int'(conv_val(chan_of(s))));
    end

    // R9 / R10 / R11 interrupt timing on slot 3
    cfg_irq(0, 3, 1, 0);
    cfg_irq(1, 3, 1, 1);
    cfg_irq(2, 3, 0, 1);
    cfg_irq(8, 11, 1, 0);
    scenario(8'h08, -1, 8'h00, 0, "R9");
    begin
      int j = -1;
      for (int k = n_start - 2; k < n_start; k++) if (seq[k] == 3) j = k;
      check(j >= 0, "R9 slot 3 serviced", j, 0);
      if (j >= 0) begin
        check(irq_cyc[1] == socc[j], "R10 early irq with soc", irq_cyc[1], socc[j]);
        check(irq_cyc[0] == socc[j] + 13, "R9 end irq 13 cycles after soc",
              irq_cyc[0], socc[j] + 13);
      end
      check(irq_cnt[0] == 1 && irq_cnt[1] == 1, "R9 one pulse per line", irq_cnt[0], 1);
      check(irq_cnt[8] == 1, "R9 line for slot 11", irq_cnt[8], 1);
      check(irq_cnt[2] == 0, "R11 disabled line silent", irq_cnt[2], 0);
    end

    scenario(8'hFF, -1, 8'h00, 0, "R5");
    scenario(8'hFF, 6, 8'h04, 4, "R6");
    scenario(8'h40, 1, 8'h40, 0, "R8");
    scenario(8'h20, 1, 8'h20, 2, "R7");

    check(irq_cnt[2] == 0, "R11 disabled line silent overall", irq_cnt[2], 0);
    check(irq_cnt[1] == irq_cnt[0], "R11 lines only for own slot", irq_cnt[1], irq_cnt[0]);
    check(soc_bad == 0, "R3 soc placement", soc_bad, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule